// File: doc/BRIEF.md
# Cascaded Biquad Bandpass Filter

This block is a sample-rate IIR bandpass filter that isolates a single narrow channel on a line carrying several frequency-multiplexed channels. It is an 8th-order recursive filter built from four second-order sections in series. Every coefficient product has its own multiplier, so each accepted input sample yields one output sample.

The filter runs on a fast system clock. A sample-enable pulse marks the cycles that carry a new input; in the intended system it fires once every ten clocks (a 10 MHz sample rate on a 100 MHz clock). Input samples are signed 14-bit values with 13 fractional bits. The output is widened to 18 bits with the same 13 fractional bits, so the full input resolution is kept at unity passband gain. When the result leaves the 18-bit range, the output clips to the nearest extreme instead of wrapping. Coefficients are fixed when the design is built. The default set places four staggered resonators near one tenth of the sample rate.

Top module: `bpf_cascade`

## Requirements
- R1: A synchronous active-high reset clears every section's stored samples and the output register to zero, and drives `y_vld` low.
- R2: Each section computes y = c0·x + c1·x[n-1] + c2·x[n-2] + c3·y[n-1] + c4·y[n-2]. Each coefficient is signed 16 bits with 14 fractional bits. Tap t of section k occupies bits [(5k+t)·16 +: 16] of `COEF`. The feedback taps c3 and c4 hold the negated denominator terms.
- R3: Section k+1 takes section k's output as its input. Each section's sum is scaled down by 2^14 with round-to-nearest (add 2^13, then arithmetic shift) and saturated to 24 bits with 13 fractional bits.
- R4: Stored samples change only at a clock edge where `smp_en` is high. Input values presented on other cycles have no effect on later outputs.
- R5: `y_out` loads the cascade result for the input present at the enabled edge and holds its value at every other edge.
- R6: `y_vld` is high for exactly the one cycle that follows each enabled edge and low otherwise.
- R7: A result above 131071 or below -131072 (in 2^-13 units) appears on `y_out` as 131071 or -131072.
- R8: The full-scale inputs -8192 and 8191 (14 bits, 13 fractional bits) are processed exactly, with no overflow in the 43-bit section sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Sample enable; qualifies `smp_in` |
| smp_in | input | 14 | Signed input sample, 13 fractional bits |
| y_out | output | 18 | Signed filtered output, 13 fractional bits, saturating |
| y_vld | output | 1 | High for one cycle after each enabled sample |

## Verification
The assertions assume that `smp_en` is never high on two consecutive cycles and that reset is never asserted in the same cycle as an enable. The output-hold and valid-pulse properties rely on that spacing. The stimulus keeps to these assumptions by issuing one enable at least every ten clocks and by asserting reset only between samples. Between enables the input is filled with random values, so any leak of non-enabled data into the filter state shows up against the reference model. A second instance with a deliberately unstable single section drives both saturation rails.

// File: rtl/bpf_pkg.sv
package bpf_pkg;
   localparam int BPF_CW   = 16;
   localparam int BPF_CF   = 14;
   localparam int BPF_NSEC = 4;
   localparam int BPF_TAPS = 5;

   // Tap order per section: feed-forward 0,1,2 then negated feedback 1,2.
   // Concatenation runs from section 3 tap 4 down to section 0 tap 0.
   localparam logic [BPF_NSEC*BPF_TAPS*BPF_CW-1:0] BPF_DEF_COEF = {
      16'hC146, 16'h6609, 16'hFF5C, 16'h0000, 16'h00A4,
      16'hC146, 16'h665E, 16'hFF5C, 16'h0000, 16'h00A4,
      16'hC146, 16'h66AB, 16'hFF5C, 16'h0000, 16'h00A4,
      16'hC146, 16'h66FF, 16'hFF5C, 16'h0000, 16'h00A4
   };
endpackage

// File: rtl/bpf_sat.sv
module bpf_sat #(
   parameter int IN_W  = 24,
   parameter int OUT_W = 18
) (
   input  logic signed [IN_W-1:0]  din,
   output logic signed [OUT_W-1:0] dout
);
   localparam int XW = IN_W - OUT_W + 1;
   localparam logic signed [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic signed [OUT_W-1:0] NEG_MAX = {1'b1, {(OUT_W-1){1'b0}}};

   generate
      if (IN_W < OUT_W) begin : g_bad
         $error("bpf_sat: IN_W must not be below OUT_W");
      end else if (IN_W == OUT_W) begin : g_pass
         assign dout = din;
      end else begin : g_clip
         logic [XW-1:0] hi;
         logic          fits;
         assign hi   = din[IN_W-1 -: XW];
         assign fits = (&hi) | (~|hi);
         always_comb begin
            if (fits)                dout = din[OUT_W-1:0];
            else if (din[IN_W-1])    dout = NEG_MAX;
            else                     dout = POS_MAX;
         end
         // R7: clipping keeps the sign of the wide value
         always_comb begin
            p_sat_sign_r7: assert (dout[OUT_W-1] == din[IN_W-1]);
         end
      end
   endgenerate
endmodule

// File: rtl/bpf_section.sv
module bpf_section #(
   parameter int IW            = 24,
   parameter int CW            = 16,
   parameter int CF            = 14,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 en,
   input  logic signed [IW-1:0] x_in,
   input  logic [5*CW-1:0]      coef,
   output logic signed [IW-1:0] y_out
);
   localparam int TAPS  = 5;
   localparam int ACC_W = IW + CW + 3;
   localparam int SH_W  = ACC_W - CF;
   localparam logic signed [ACC_W-1:0] HALF =
      ROUND_NEAREST ? (ACC_W'(1) <<< (CF-1)) : '0;

   logic signed [IW-1:0]    x1, x2, y1, y2;
   logic signed [IW-1:0]    tap   [TAPS];
   logic signed [ACC_W-1:0] prod  [TAPS];
   logic signed [ACC_W-1:0] sum;
   logic signed [ACC_W-1:0] sum_r;
   logic signed [SH_W-1:0]  narrow;

   assign tap[0] = x_in;
   assign tap[1] = x1;
   assign tap[2] = x2;
   assign tap[3] = y1;
   assign tap[4] = y2;

   generate
      for (genvar t = 0; t < TAPS; t++) begin : g_mul
         logic signed [CW-1:0]    c;
         logic signed [ACC_W-1:0] a_ext, c_ext;
         assign c       = coef[t*CW +: CW];
         assign a_ext   = ACC_W'(tap[t]);
         assign c_ext   = ACC_W'(c);
         assign prod[t] = a_ext * c_ext;
      end
   endgenerate

   always_comb begin
      sum = '0;
      for (int t = 0; t < TAPS; t++) sum = sum + prod[t];
   end

   assign sum_r  = sum + HALF;
   assign narrow = SH_W'(sum_r >>> CF);

   bpf_sat #(.IN_W(SH_W), .OUT_W(IW)) u_sat (
      .din  (narrow),
      .dout (y_out)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         x1 <= '0;
         x2 <= '0;
         y1 <= '0;
         y2 <= '0;
      end else if (en) begin
         x1 <= x_in;
         x2 <= x1;
         y1 <= y_out;
         y2 <= y1;
      end
   end

   // R4: stored samples hold on cycles without enable
   p_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable({x1, x2, y1, y2}));

   // R2: delay lines advance by one position per accepted sample
   p_shift_r2: assert property (@(posedge clk) disable iff (rst)
      en |=> (x2 == $past(x1)) && (y2 == $past(y1)));

   // R1: state is zero right after reset
   p_reset_r1: assert property (@(posedge clk)
      rst |=> (x1 == '0) && (x2 == '0) && (y1 == '0) && (y2 == '0));
endmodule

// File: rtl/bpf_cascade.sv
module bpf_cascade
   import bpf_pkg::*;
#(
   parameter int  IN_W          = 14,
   parameter int  OUT_W         = 18,
   parameter int  IW            = 24,
   parameter int  CW            = BPF_CW,
   parameter int  CF            = BPF_CF,
   parameter int  NSEC          = BPF_NSEC,
   parameter bit  ROUND_NEAREST = 1'b1,
   parameter logic [NSEC*BPF_TAPS*CW-1:0] COEF = BPF_DEF_COEF
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    smp_en,
   input  logic signed [IN_W-1:0]  smp_in,
   output logic signed [OUT_W-1:0] y_out,
   output logic                    y_vld
);
   localparam int SEC_CW = BPF_TAPS * CW;

   generate
      if (NSEC < 1)        begin : g_e0 $error("bpf_cascade: NSEC < 1"); end
      if (IN_W < 2)        begin : g_e1 $error("bpf_cascade: IN_W < 2"); end
      if (OUT_W < IN_W)    begin : g_e2 $error("bpf_cascade: OUT_W < IN_W"); end
      if (IW < OUT_W)      begin : g_e3 $error("bpf_cascade: IW < OUT_W"); end
      if (CF < 1 || CF >= CW) begin : g_e4 $error("bpf_cascade: bad CF"); end
   endgenerate

   logic signed [IW-1:0]    stage [NSEC+1];
   logic signed [OUT_W-1:0] y_clip;

   assign stage[0] = IW'(smp_in);

   generate
      for (genvar k = 0; k < NSEC; k++) begin : g_sec
         bpf_section #(
            .IW(IW), .CW(CW), .CF(CF), .ROUND_NEAREST(ROUND_NEAREST)
         ) u_sec (
            .clk   (clk),
            .rst   (rst),
            .en    (smp_en),
            .x_in  (stage[k]),
            .coef  (COEF[k*SEC_CW +: SEC_CW]),
            .y_out (stage[k+1])
         );
      end
   endgenerate

   bpf_sat #(.IN_W(IW), .OUT_W(OUT_W)) u_out_sat (
      .din  (stage[NSEC]),
      .dout (y_clip)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         y_out <= '0;
         y_vld <= 1'b0;
      end else begin
         y_vld <= smp_en;
         if (smp_en) y_out <= y_clip;
      end
   end

   // Input assumption: enables are never back to back
   p_en_gap: assert property (@(posedge clk) disable iff (rst)
      smp_en |=> !smp_en);

   // R6: a valid cycle is always preceded by an enable
   p_vld_src_r6: assert property (@(posedge clk) disable iff (rst)
      y_vld |-> $past(smp_en));

   // R6: valid never lasts two cycles under spaced enables
   p_vld_pulse_r6: assert property (@(posedge clk) disable iff (rst)
      y_vld |=> !y_vld);

   // R5: the output only moves in a valid cycle
   p_out_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !y_vld |-> $stable(y_out));

   // R1: output register and flag clear on reset
   p_out_reset_r1: assert property (@(posedge clk)
      rst |=> (y_out == '0) && !y_vld);
endmodule

// File: tb/bpf_cascade_tb.sv
module bpf_cascade_tb;
   import bpf_pkg::*;

   localparam logic [79:0] HOT_COEF = {16'h0000, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en  = 1'b0;
   logic signed [13:0] xa = '0, xb = '0;
   logic signed [17:0] ya, yb;
   logic va, vb;

   int n_chk  = 0;
   int n_fail = 0;
   longint sta [4][4];
   longint stb [4][4];
   longint expa = 0, expb = 0;

   always #10 clk = ~clk;

   bpf_cascade u_dut (
      .clk(clk), .rst(rst), .smp_en(en), .smp_in(xa), .y_out(ya), .y_vld(va)
   );

   bpf_cascade #(.NSEC(1), .COEF(HOT_COEF)) u_dut_hot (
      .clk(clk), .rst(rst), .smp_en(en), .smp_in(xb), .y_out(yb), .y_vld(vb)
   );

   function automatic longint clampw(input longint v, input int w);
      longint hi = (longint'(1) <<< (w-1)) - 1;
      longint lo = -(longint'(1) <<< (w-1));
      if (v > hi) return hi;
      if (v < lo) return lo;
      return v;
   endfunction

   function automatic longint model_step(input logic [319:0] cf, input int ns,
                                         input longint xin, inout longint st[4][4]);
      longint s = xin;
      for (int k = 0; k < ns; k++) begin
         longint c [5];
         longint acc;
         longint y;
         for (int t = 0; t < 5; t++) c[t] = longint'($signed(cf[(k*5+t)*16 +: 16]));
         acc = c[0]*s + c[1]*st[k][0] + c[2]*st[k][1] + c[3]*st[k][2] + c[4]*st[k][3];
         y = clampw((acc + 64'sd8192) >>> 14, 24);
         st[k][1] = st[k][0];
         st[k][0] = s;
         st[k][3] = st[k][2];
         st[k][2] = y;
         s = y;
      end
      return clampw(s, 18);
   endfunction

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic clear_model();
      for (int k = 0; k < 4; k++)
         for (int j = 0; j < 4; j++) begin
            sta[k][j] = 0;
            stb[k][j] = 0;
         end
      expa = 0;
      expb = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      en  = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      clear_model();
      chk("R1 reset out", ya, 0);
      chk("R1 reset vld", va, 0);
      chk("R1 reset hot out", yb, 0);
   endtask

   task automatic do_sample(input int a, input int b, input string req);
      @(negedge clk);
      en = 1'b1;
      xa = 14'(a);
      xb = 14'(b);
      expa = model_step(BPF_DEF_COEF, 4, longint'(a), sta);
      expb = model_step({240'd0, HOT_COEF}, 1, longint'(b), stb);
      @(negedge clk);
      en = 1'b0;
      xa = 14'($urandom);
      xb = 14'($urandom);
      chk("R6 vld after enable", va, 1);
      chk(req, ya, expa);
      chk("R7 hot section", yb, expb);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         xa = 14'($urandom);
         xb = 14'($urandom);
         chk("R6 vld low", va, 0);
         chk("R5 hold", ya, expa);
         chk("R4 ignored input", yb, expb);
      end
   endtask

   function automatic int tone(input int n, input real f, input real amp);
      return int'($rtoi(amp * $sin(2.0 * 3.14159265358979 * f * n)));
   endfunction

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240611));
      clear_model();
      do_reset();

      // R2 impulse response through the cascade
      do_sample(8191, 0, "R2 impulse");
      for (int n = 0; n < 250; n++) do_sample(0, 0, "R2 impulse tail");

      // R3 centre-band tone (0.1 fs) then adjacent tone (0.091 fs)
      for (int n = 0; n < 400; n++) do_sample(tone(n, 0.1, 4000.0), n % 7, "R3 centre tone");
      for (int n = 0; n < 300; n++) do_sample(tone(n, 0.091, 4000.0), -(n % 5), "R3 adjacent tone");

      // R8 full-scale corners
      for (int n = 0; n < 40; n++) do_sample((n % 2) ? 8191 : -8192, 0, "R8 full scale");
      for (int n = 0; n < 20; n++) do_sample(-8192, 0, "R8 negative rail input");

      // Random samples
      for (int n = 0; n < 300; n++)
         do_sample(int'($signed(14'($urandom))), int'($signed(14'($urandom))), "R2 random");

      // R1 reset mid-stream, then R7 positive rail
      do_reset();
      for (int n = 0; n < 30; n++) do_sample(0, 4096, "R2 after reset");
      chk("R7 positive rail", yb, 131071);

      do_reset();
      for (int n = 0; n < 30; n++) do_sample(0, -4096, "R2 after reset");
      chk("R7 negative rail", yb, -131072);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule